// File: doc/BRIEF.md
# Segment Identifier Scrambler

The block turns a segment request into a scrambled virtual segment identifier. A request is either a kernel access, where the segment number of the effective address is itself the 36-bit proto identifier, or a user access, where a 19-bit context is placed above the low segment bits of the effective address. The proto identifier is multiplied by the fixed prime 200730139 and the product is reduced modulo 2^36-1. The reduction adds the upper and lower halves of the product and then applies one end-around correction, so no divider and no second multiplier are needed. Because the multiplier is co-prime to the modulus, distinct legal proto identifiers give distinct results.

The datapath has three register stages: multiply, fold and correct. Requests enter through a valid/ready input stream and leave through a valid/ready output stream. A request transfers when `in_valid` and `in_ready` are both high at a rising clock edge, and a result transfers when `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low the whole pipeline holds, the output stays unchanged and `in_ready` is low. With `out_ready` held high the block takes one request per cycle. A request whose proto identifier would be reserved or out of range comes out with an error flag and a zero identifier.

Top module: `vsid_scrambler`

## Requirements
- R1: For a request without error, `out_vsid` equals (proto × 200730139) mod (2^36−1), where proto is the identifier given by R2 or R3.
- R2: With `in_user` = 0 (kernel), proto equals `in_seg`, the 36 bits of the effective address above bit 27.
- R3: With `in_user` = 1 (user), proto equals `in_ctx` × 2^16 + `in_seg`[12:0], valid when `in_seg`[35:13] is zero (effective address below 2^41).
- R4: A user request with any of `in_seg`[35:13] set yields `out_err` = 1 and `out_vsid` = 0.
- R5: A kernel request with `in_seg` all ones (the reserved proto value) yields `out_err` = 1 and `out_vsid` = 0.
- R6: With `out_ready` held high, a request accepted at a clock edge has its result on the outputs after the second following edge, that is in the third cycle after the cycle in which it was offered, and back-to-back requests are accepted every cycle.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_valid`, `out_vsid` and `out_err` keep their values at the next edge.
- R8: Results leave in the order their requests were accepted, each exactly once.
- R9: A result without error is never the all-ones 36-bit value.
- R10: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Block can take a request this cycle |
| in_user | input | 1 | 0 = kernel request, 1 = user request |
| in_seg | input | 36 | Effective address bits 63:28 |
| in_ctx | input | 19 | User context (ignored for kernel requests) |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_vsid | output | 36 | Scrambled identifier, zero on error |
| out_err | output | 1 | Request was reserved or out of range |

## Verification
A request offered in cycle c and accepted at the edge that closes it is due on the outputs in cycle c+3 when the consumer never stalls, one register per stage of multiply, fold and correct. The bench drives inputs at the falling edge, samples one nanosecond later, and records the cycle of each accepted request, so a directed run with `out_ready` held high checks that exact offset for every result. Under random back-pressure the bench does not check a fixed offset; it checks the order of results against a queue of expected values and that a stalled output stays the same into the next cycle.

// File: rtl/vsid_pkg.sv
`timescale 1ns/1ps
package vsid_pkg;
  localparam int EA_BITS        = 64;
  localparam int SID_SHIFT      = 28;
  localparam int VSID_BITS      = 36;
  localparam int MUL_BITS       = 28;
  localparam int CTX_BITS       = 19;
  localparam int USER_ESID_BITS = 16;
  localparam int USER_EA_BITS   = 41;
  localparam int SEG_BITS       = EA_BITS - SID_SHIFT;
  localparam int USER_SEG_BITS  = USER_EA_BITS - SID_SHIFT;
  localparam int PROD_BITS      = VSID_BITS + MUL_BITS;
  localparam logic [MUL_BITS-1:0] VSID_MULT = 28'd200730139;

  typedef enum logic {SRC_KERNEL = 1'b0, SRC_USER = 1'b1} src_e;
endpackage

// File: rtl/vsid_front.sv
`timescale 1ns/1ps
module vsid_front #(
  parameter int SEG_W      = vsid_pkg::SEG_BITS,
  parameter int CTX_W      = vsid_pkg::CTX_BITS,
  parameter int PROTO_W    = vsid_pkg::VSID_BITS,
  parameter int USER_SEG_W = vsid_pkg::USER_SEG_BITS,
  parameter int USER_SHIFT = vsid_pkg::USER_ESID_BITS
) (
  input  logic               is_user,
  input  logic [SEG_W-1:0]   seg,
  input  logic [CTX_W-1:0]   ctx,
  output logic [PROTO_W-1:0] proto,
  output logic               bad
);
  logic [PROTO_W-1:0] user_proto, kern_proto;
  logic               user_over, kern_rsvd;

  // user addresses must sit below the user address ceiling
  assign user_over  = |seg[SEG_W-1:USER_SEG_W];
  assign user_proto = (PROTO_W'(ctx) << USER_SHIFT) | PROTO_W'(seg[USER_SEG_W-1:0]);
  // kernel proto is the segment number itself; all ones is reserved
  assign kern_proto = PROTO_W'(seg);
  assign kern_rsvd  = &seg;

  always_comb begin
    if (vsid_pkg::src_e'(is_user) == vsid_pkg::SRC_USER) begin
      proto = user_proto;
      bad   = user_over;
    end else begin
      proto = kern_proto;
      bad   = kern_rsvd;
    end
  end
endmodule

// File: rtl/vsid_fold.sv
`timescale 1ns/1ps
module vsid_fold #(
  parameter int W    = vsid_pkg::VSID_BITS,
  parameter int HI_W = vsid_pkg::MUL_BITS
) (
  input  logic [W+HI_W-1:0] prod,
  output logic [W:0]        sum
);
  // 2^W == 1 (mod 2^W-1): the upper part folds onto the lower part
  assign sum = (W+1)'(prod[W-1:0]) + (W+1)'(prod[W+HI_W-1:W]);
endmodule

// File: rtl/vsid_correct.sv
`timescale 1ns/1ps
module vsid_correct #(
  parameter int W = vsid_pkg::VSID_BITS
) (
  input  logic [W:0]   sum,
  output logic [W-1:0] vsid
);
  logic [W:0] inc;
  // sum+1 overflows into bit W exactly when sum >= 2^W-1
  assign inc  = sum + (W+1)'(1);
  assign vsid = sum[W-1:0] + W'(inc[W]);
endmodule

// File: rtl/vsid_scrambler.sv
`timescale 1ns/1ps
module vsid_scrambler #(
  parameter int SEG_W  = vsid_pkg::SEG_BITS,
  parameter int CTX_W  = vsid_pkg::CTX_BITS,
  parameter int VSID_W = vsid_pkg::VSID_BITS,
  parameter int MUL_W  = vsid_pkg::MUL_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_user,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic [CTX_W-1:0]  in_ctx,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [VSID_W-1:0] out_vsid,
  output logic              out_err
);
  localparam int PROD_W = VSID_W + MUL_W;

  logic [VSID_W-1:0] proto;
  logic              proto_bad;
  logic              adv;

  logic              s1_v, s1_err;
  logic [PROD_W-1:0] s1_prod;
  logic              s2_v, s2_err;
  logic [VSID_W:0]   s2_sum, fold_sum;
  logic              s3_v, s3_err;
  logic [VSID_W-1:0] s3_vsid, corr_vsid;

  vsid_front #(
    .SEG_W(SEG_W), .CTX_W(CTX_W), .PROTO_W(VSID_W),
    .USER_SEG_W(vsid_pkg::USER_SEG_BITS), .USER_SHIFT(vsid_pkg::USER_ESID_BITS)
  ) u_front (
    .is_user(in_user), .seg(in_seg), .ctx(in_ctx), .proto(proto), .bad(proto_bad)
  );

  vsid_fold #(.W(VSID_W), .HI_W(MUL_W)) u_fold (.prod(s1_prod), .sum(fold_sum));
  vsid_correct #(.W(VSID_W)) u_corr (.sum(s2_sum), .vsid(corr_vsid));

  // the whole pipe moves unless a finished result is waiting
  assign adv      = !s3_v || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0; s2_v <= 1'b0; s3_v <= 1'b0;
      s1_err <= 1'b0; s2_err <= 1'b0; s3_err <= 1'b0;
      s1_prod <= '0; s2_sum <= '0; s3_vsid <= '0;
    end else if (adv) begin
      s1_v    <= in_valid;
      s1_err  <= proto_bad;
      s1_prod <= PROD_W'(proto) * PROD_W'(vsid_pkg::VSID_MULT);
      s2_v    <= s1_v;
      s2_err  <= s1_err;
      s2_sum  <= fold_sum;
      s3_v    <= s2_v;
      s3_err  <= s2_err;
      s3_vsid <= s2_err ? '0 : corr_vsid;
    end
  end

  assign out_valid = s3_v;
  assign out_vsid  = s3_vsid;
  assign out_err   = s3_err;

  // R7
  hold_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_vsid) && $stable(out_err));
  // R7
  no_accept_when_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R4 R5
  error_gives_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_vsid == '0);
  // R9
  no_reserved_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_vsid != '1);
  // R6
  fill_one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(adv) && $past(s2_v) |-> s3_v);
endmodule

// File: tb/sim_vsid_scrambler.sv
`timescale 1ns/1ps
module sim_vsid_scrambler;
  localparam logic [63:0] MULT = 64'd200730139;
  localparam logic [63:0] MODV = 64'h0000_000F_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_user = 1'b0;
  logic [35:0] in_seg = '0;
  logic [18:0] in_ctx = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_vsid;
  logic        out_err;

  typedef struct {
    logic [35:0] v;
    logic        e;
    int          acc;
    bit          lat;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0, bad = 0, cyc = 0, n_in = 0, n_out = 0;
  bit   lat_mode = 1'b1, rand_ready = 1'b0, done = 1'b0;
  bit   prev_stall = 1'b0;
  logic [35:0] prev_vsid;
  logic        prev_err;

  vsid_scrambler u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_user(in_user), .in_seg(in_seg), .in_ctx(in_ctx),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_vsid(out_vsid), .out_err(out_err)
  );

  always #10 clk = ~clk;

  function automatic logic [35:0] ref_vsid(input logic [35:0] p);
    logic [63:0] w;
    w = {28'b0, p} * MULT;
    return 36'(w % MODV);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) begin
    cyc <= cyc + 1;
    out_ready <= rand_ready ? (($urandom % 4) != 0) : 1'b1;
  end

  // output monitor, one nanosecond after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (prev_stall) begin
        check(out_valid == 1'b1, "R7 valid held", 64'(out_valid), 64'd1);
        check(out_vsid == prev_vsid && out_err == prev_err, "R7 data held",
              64'(out_vsid), 64'(prev_vsid));
      end
      prev_stall = out_valid && !out_ready;
      prev_vsid  = out_vsid;
      prev_err   = out_err;
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R7 in_ready low", 64'(in_ready), 64'd0);
      if (out_valid && out_ready) begin
        n_out++;
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 extra result", 64'(out_vsid), 64'd0);
        end else begin
          exp_t x;
          x = exp_q.pop_front();
          check(out_vsid == x.v, {"R1 R8 ", x.req, " value"}, 64'(out_vsid), 64'(x.v));
          check(out_err == x.e, {x.req, " error flag"}, 64'(out_err), 64'(x.e));
          if (!out_err)
            check(out_vsid != '1, "R9 not all ones", 64'(out_vsid), 64'h0);
          if (x.lat)
            check(cyc - x.acc == 3, "R6 latency", 64'(cyc - x.acc), 64'd3);
        end
      end
    end
  end

  task automatic send(input logic user, input logic [35:0] seg, input logic [18:0] ctx);
    exp_t x;
    logic [35:0] p;
    in_valid = 1'b1; in_user = user; in_seg = seg; in_ctx = ctx;
    if (user) begin
      p = 36'(ctx) * 36'd65536 + 36'(seg[12:0]);
      if (seg[35:13] != 0) begin x.v = '0; x.e = 1'b1; x.req = "R4"; end
      else begin x.v = ref_vsid(p); x.e = 1'b0; x.req = "R3"; end
    end else begin
      if (seg == '1) begin x.v = '0; x.e = 1'b1; x.req = "R5"; end
      else begin x.v = ref_vsid(seg); x.e = 1'b0; x.req = "R2"; end
    end
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    x.acc = cyc;
    x.lat = lat_mode;
    exp_q.push_back(x);
    n_in++;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R10 out_valid after reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R10 in_ready after reset", 64'(in_ready), 64'd1);
    @(negedge clk);
    // directed, no back-pressure, back to back (R6)
    send(1'b0, 36'd0, 19'd0);
    send(1'b0, 36'd1, 19'd0);
    send(1'b0, 36'hF_FFFF_FFFE, 19'd0);
    send(1'b0, 36'hC_0000_0000, 19'd0);
    send(1'b1, 36'h0_0000_1FFF, 19'h7FFFF);
    send(1'b1, 36'h0_0000_0005, 19'd0);
    send(1'b1, 36'h0_0000_2000, 19'd3);   // R4 just above user ceiling
    send(1'b0, 36'hF_FFFF_FFFF, 19'd0);   // R5 reserved proto
    send(1'b1, 36'h8_0000_0000, 19'd1);   // R4 far above
    send(1'b0, 36'hF_FFFF_FFF0, 19'h1234); // R2 context ignored
    repeat (6) @(negedge clk);
    // random with back-pressure (R7 R8)
    lat_mode   = 1'b0;
    rand_ready = 1'b1;
    for (int i = 0; i < 400; i++) begin
      logic        u;
      logic [35:0] s;
      logic [18:0] c;
      u = 1'($urandom);
      c = 19'($urandom);
      if (u) s = (($urandom % 8) == 0) ? {4'($urandom), 32'($urandom)} : 36'(13'($urandom));
      else   s = (($urandom % 16) == 0) ? '1 : {2'b11, 2'($urandom), 32'($urandom)};
      send(u, s, c);
      if (($urandom % 4) == 0) repeat ($urandom % 3) @(negedge clk);
    end
    rand_ready = 1'b0;
    repeat (20) @(negedge clk);
    check(exp_q.size() == 0 && n_in == n_out, "R8 all results delivered",
          64'(n_out), 64'(n_in));
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end
endmodule